// File: doc/BRIEF.md
# Motor Bridge Fault Protection Sequencer

This block sits between the protection comparators of a brushed-motor H-bridge and its gate control. It takes three fault indications: a supply-undervoltage flag, an overtemperature flag whose hysteresis is already applied, and a raw overcurrent comparator bit. From them it produces one command that turns off every bridge switch and one enable that pulls the active-low open-drain fault pin to ground. All three inputs may arrive without a relation to the clock, so each one first passes through a synchronizer chain.

Undervoltage and overtemperature act on their level. The bridge is off while either flag is high, and it comes back on by itself once the flag drops. Overcurrent is filtered first. The synchronized bit must stay high for a number of consecutive clock cycles before it counts as a fault, and any low cycle restarts that count. A confirmed overcurrent holds the bridge off for a fixed retry interval. When the interval ends, the bridge follows its drive inputs again. If the overcurrent bit is still high, the filter and retry sequence runs again. All lengths are parameters in clock cycles. With a 200 MHz clock, the defaults are a 2 µs filter and a 3 ms retry.

Top module: `fault_guard`

## Requirements
- R1: Undervoltage forces `bridge_off_o` high in the third sampling cycle after `uv_flag_i` rises, and releases it in the third cycle after the flag falls when no other fault is active. This latency is SYNC_STAGES synchronizer flops plus one output flop, with SYNC_STAGES = 2.
- R2: Overtemperature behaves the same way through `ot_flag_i`, with the same three-cycle latency in both directions.
- R3: The overcurrent bit is ignored when, after synchronization, it stays high for fewer than DEGLITCH_CYC consecutive cycles. Any single low cycle restarts the count, so two short pulses separated by one low cycle never trip.
- R4: If `oc_raw_i` stays high for DEGLITCH_CYC consecutive cycles from a change at cycle n, `bridge_off_o` is high from cycle n+3+DEGLITCH_CYC for exactly RETRY_CYC cycles.
- R5: When the retry interval ends, the bridge is enabled again. If the overcurrent bit is still high, it is filtered again and trips again DEGLITCH_CYC cycles later. While a retry runs, the overcurrent bit has no effect.
- R6: `flt_pull_o` equals `bridge_off_o` in every cycle. A value of 1 means the fault pin is pulled low, and 0 means the pin is released to high impedance.
- R7: When faults overlap, `bridge_off_o` stays high until every level fault has cleared and any running retry interval has finished.
- R8: While `rst_n` is low, both outputs are 0 and all timers are cleared, whatever the flag inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_flag_i | input | 1 | Supply undervoltage flag, asynchronous, 1 = fault |
| ot_flag_i | input | 1 | Overtemperature flag with hysteresis applied, asynchronous, 1 = fault |
| oc_raw_i | input | 1 | Raw overcurrent comparator bit, asynchronous, 1 = over limit |
| bridge_off_o | output | 1 | 1 = turn off all bridge switches |
| flt_pull_o | output | 1 | 1 = pull the open-drain fault pin low |

## Verification
The assertions assume the following about the inputs:
- Every flag is a clean level that the synchronizer can sample, so each stage holds the previous stage's value from one cycle earlier.
- DEGLITCH_CYC and RETRY_CYC are at least 1, so the retry counter always reaches its terminal value.

The stimulus follows these assumptions. It changes inputs only at falling clock edges and holds every level for at least one full cycle. It uses short timer parameters so that pulses lasting exactly one cycle less than, or exactly equal to, the filter length land on known cycles.

// File: rtl/fg_pkg.sv
// Shared types for the fault guard.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package fg_pkg;

    // Overcurrent sequencer states.
    typedef enum logic {
        OC_WATCH = 1'b0,
        OC_RETRY = 1'b1
    } oc_state_t;

    // Synchronized fault flags as a bundle.
    typedef struct packed {
        logic oc;
        logic ot;
        logic uv;
    } flag_set_t;

endpackage

// File: rtl/fg_sync.sv
// Multi-bit flop-chain synchronizer. Each bit is synchronized on its own.
// Assumes: the bits are unrelated levels, so no coherency between bits is needed.
module fg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg;

    // Purpose: shift the raw inputs through the chain; reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

    // R1: the first stage captures the input port value of the previous cycle
    a_r1_stage_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stg[0] == $past(d_i)));

endmodule

// File: rtl/fg_oc_seq.sv
// Overcurrent deglitch filter and timed auto-retry sequencer.
// In WATCH, it counts consecutive high cycles of the synchronized overcurrent bit.
// A low cycle restarts the count. Reaching DEGLITCH_CYC enters RETRY, which holds
// busy_o for RETRY_CYC cycles and then returns to WATCH with a cleared count.
// Assumes: oc_i is already synchronous; DEGLITCH_CYC >= 1 and RETRY_CYC >= 1.
module fg_oc_seq
    import fg_pkg::*;
#(
    parameter int DEGLITCH_CYC = 400,
    parameter int RETRY_CYC    = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_i,
    output logic busy_o
);

    localparam int GL_W = $clog2(DEGLITCH_CYC + 1);
    localparam int RT_W = $clog2(RETRY_CYC + 1);
    localparam logic [GL_W-1:0] GL_LAST = GL_W'(DEGLITCH_CYC - 1);
    localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRY_CYC - 1);

    oc_state_t       state_q;
    logic [GL_W-1:0] gl_q;
    logic [RT_W-1:0] rt_q;

    // Purpose: advance the deglitch count or the retry timer, depending on the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OC_WATCH;
            gl_q    <= '0;
            rt_q    <= '0;
        end else begin
            case (state_q)
                OC_WATCH: begin
                    rt_q <= '0;
                    if (!oc_i) begin
                        gl_q <= '0;
                    end else if (gl_q == GL_LAST) begin
                        state_q <= OC_RETRY;
                        gl_q    <= '0;
                    end else begin
                        gl_q <= gl_q + 1'b1;
                    end
                end
                default: begin
                    gl_q <= '0;
                    if (rt_q == RT_LAST) begin
                        state_q <= OC_WATCH;
                        rt_q    <= '0;
                    end else begin
                        rt_q <= rt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q == OC_RETRY);

    // R3: a trip is only ever entered while the overcurrent bit was high
    a_r3_trip_needs_oc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(oc_i));

    // R4: the retry interval cannot end before its terminal count
    a_r4_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rt_q != RT_LAST) |=> busy_o);

    // R5: at its terminal count, the retry releases and filtering starts from zero
    a_r5_retry_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rt_q == RT_LAST) |=> (!busy_o && gl_q == '0));

    // R4: the retry timer stays inside its interval
    a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q <= RT_LAST);

endmodule

// File: rtl/fg_merge.sv
// Merges the active fault sources into registered bridge-off and fault-pin enables.
// Assumes: every source is a synchronous level; one output flop per output keeps
// both outputs free of glitches.
module fg_merge #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic             off_o,
    output logic             pull_o
);

    logic any_fault;

    // Purpose: OR-reduce all the sources.
    always_comb begin
        any_fault = |src_i;
    end

    // Purpose: register both outputs; reset releases the bridge and the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_o  <= 1'b0;
            pull_o <= 1'b0;
        end else begin
            off_o  <= any_fault;
            pull_o <= any_fault;
        end
    end

endmodule

// File: rtl/fault_guard.sv
// Top level of the fault guard. It synchronizes the three flags, filters
// overcurrent and runs its auto-retry, then merges everything into the
// bridge-off and fault-pin-pull outputs.
// Assumes: the flags are asynchronous levels; timer lengths are given in clock cycles.
module fault_guard
    import fg_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DEGLITCH_CYC = 400,
    parameter int RETRY_CYC    = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag_i,
    input  logic ot_flag_i,
    input  logic oc_raw_i,
    output logic bridge_off_o,
    output logic flt_pull_o
);

    localparam int N_FLAGS = $bits(flag_set_t);

    flag_set_t raw_flags;
    flag_set_t syn_flags;
    logic      oc_busy;

    // Purpose: bundle the raw flags for the synchronizer.
    always_comb begin
        raw_flags.oc = oc_raw_i;
        raw_flags.ot = ot_flag_i;
        raw_flags.uv = uv_flag_i;
    end

    fg_sync #(
        .W      (N_FLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (syn_flags)
    );

    fg_oc_seq #(
        .DEGLITCH_CYC (DEGLITCH_CYC),
        .RETRY_CYC    (RETRY_CYC)
    ) u_oc_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .oc_i   (syn_flags.oc),
        .busy_o (oc_busy)
    );

    fg_merge #(
        .N_SRC (3)
    ) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  ({oc_busy, syn_flags.ot, syn_flags.uv}),
        .off_o  (bridge_off_o),
        .pull_o (flt_pull_o)
    );

endmodule

// File: tb/fault_guard_bench.sv
`timescale 1ns/1ps
module fault_guard_bench;

    localparam int D   = 8;
    localparam int R   = 40;
    localparam int LAT = 3;   // two synchronizer flops plus one output flop

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 1'b0, ot = 1'b0, oc = 1'b0;
    logic bridge_off_o, flt_pull_o;
    int   cyc = 0;
    int   checks = 0, fails = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    fault_guard #(.SYNC_STAGES(2), .DEGLITCH_CYC(D), .RETRY_CYC(R)) u_fault_guard (
        .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .ot_flag_i(ot), .oc_raw_i(oc),
        .bridge_off_o(bridge_off_o), .flt_pull_o(flt_pull_o)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic expect_off(input int at, input logic v, input string tag);
        exp_q.push_back('{at, v, tag});
    endtask

    task automatic direct_check(input logic v, input string tag);
        checks++;
        if (bridge_off_o !== v || flt_pull_o !== v) begin
            fails++;
            $display("FAIL %s: off=%b pull=%b expected %b", tag, bridge_off_o, flt_pull_o, v);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: pop the scoreboard items that are due and compare them; R6 is checked on every item
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                checks += 2;
                if (it.at != cyc || bridge_off_o !== it.val) begin
                    fails++;
                    $display("FAIL %s: cyc %0d (due %0d) off=%b expected %b",
                             it.tag, cyc, it.at, bridge_off_o, it.val);
                end
                if (flt_pull_o !== it.val) begin
                    fails++;
                    $display("FAIL R6: cyc %0d pull=%b expected %b", cyc, flt_pull_o, it.val);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int n, p;
        // R8: outputs stay low under reset even with a flag raised
        uv = 1'b1;
        repeat (4) @(negedge clk);
        direct_check(1'b0, "R8 reset with flag high");
        uv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        direct_check(1'b0, "R8 after reset release");

        // R1: undervoltage level with its latency
        @(negedge clk); uv = 1'b1; n = cyc;
        expect_off(n + LAT - 1, 1'b0, "R1 before assert");
        expect_off(n + LAT,     1'b1, "R1 assert");
        expect_off(n + LAT + 5, 1'b1, "R1 held");
        repeat (10) @(negedge clk); uv = 1'b0; n = cyc;
        expect_off(n + LAT - 1, 1'b1, "R1 before release");
        expect_off(n + LAT,     1'b0, "R1 release");
        drain();

        // R2: overtemperature level with its latency
        @(negedge clk); ot = 1'b1; n = cyc;
        expect_off(n + LAT - 1, 1'b0, "R2 before assert");
        expect_off(n + LAT,     1'b1, "R2 assert");
        repeat (6) @(negedge clk); ot = 1'b0; n = cyc;
        expect_off(n + LAT - 1, 1'b1, "R2 before release");
        expect_off(n + LAT,     1'b0, "R2 release");
        drain();

        // R3: two pulses of D-1 cycles with one low cycle between them never trip
        @(negedge clk); oc = 1'b1; n = cyc;
        expect_off(n + D + LAT,         1'b0, "R3 first short pulse");
        expect_off(n + 2 * D + LAT + 3, 1'b0, "R3 second short pulse");
        repeat (D - 1) @(negedge clk); oc = 1'b0;
        @(negedge clk); oc = 1'b1;
        repeat (D - 1) @(negedge clk); oc = 1'b0;
        drain();

        // R4: a pulse of exactly D cycles trips, and the bridge is off for exactly R cycles
        @(negedge clk); oc = 1'b1; n = cyc;
        expect_off(n + 2 + D,     1'b0, "R4 before trip");
        expect_off(n + 3 + D,     1'b1, "R4 trip");
        expect_off(n + 2 + D + R, 1'b1, "R4 last retry cycle");
        expect_off(n + 3 + D + R, 1'b0, "R4 retry end");
        repeat (D) @(negedge clk); oc = 1'b0;
        drain();

        // R5: a persistent overcurrent repeats the sequence; oc is ignored while a retry runs
        @(negedge clk); oc = 1'b1; n = cyc;
        expect_off(n + 3 + D,             1'b1, "R5 first trip");
        expect_off(n + 3 + D + R,         1'b0, "R5 re-enable");
        expect_off(n + 2 + 2 * D + R,     1'b0, "R5 refilter window");
        expect_off(n + 3 + 2 * D + R,     1'b1, "R5 second trip");
        expect_off(n + 2 + 2 * D + 2 * R, 1'b1, "R5 retry ignores oc drop");
        expect_off(n + 3 + 2 * D + 2 * R, 1'b0, "R5 final release");
        repeat (3 + 2 * D + R + 5) @(negedge clk); oc = 1'b0;
        drain();

        // R7: undervoltage inside a retry does not shorten or extend it
        @(negedge clk); oc = 1'b1; n = cyc;
        expect_off(n + 2 + D + R, 1'b1, "R7 retry with uv inside");
        expect_off(n + 3 + D + R, 1'b0, "R7 release after retry");
        repeat (D) @(negedge clk); oc = 1'b0;
        repeat (5) @(negedge clk); uv = 1'b1;
        repeat (10) @(negedge clk); uv = 1'b0;
        drain();

        // R7: overtemperature raised inside a retry and held past its end keeps the bridge off
        @(negedge clk); oc = 1'b1; n = cyc;
        p = n + D + R + 10;
        expect_off(n + D + 20,    1'b1, "R7 retry with ot");
        expect_off(n + 3 + D + R, 1'b1, "R7 ot outlasts retry");
        expect_off(p + LAT - 1,   1'b1, "R7 before ot release");
        expect_off(p + LAT,       1'b0, "R7 all clear");
        repeat (D) @(negedge clk); oc = 1'b0;
        repeat (15) @(negedge clk); ot = 1'b1;
        while (cyc < p) @(negedge clk);
        ot = 1'b0;
        drain();

        // R7: overlapping level faults release only after the last one clears
        @(negedge clk); uv = 1'b1; ot = 1'b1;
        repeat (5) @(negedge clk); uv = 1'b0; n = cyc;
        expect_off(n + LAT + 2, 1'b1, "R7 ot still active");
        repeat (6) @(negedge clk); ot = 1'b0; n = cyc;
        expect_off(n + LAT, 1'b0, "R7 both cleared");
        drain();

        report();
        $finish;
    end

endmodule